// File: doc/BRIEF.md
# Single-Bit Boolean Processor

This unit carries out one-bit logic on a carry flag and on any bit of a flat 256-bit address space. The bits live either in a window of bit-addressable RAM bytes or in the bit-addressable special-register bytes. The requester pulses `start` with an operation code, a bit address and the present carry value. The unit maps the bit address to a byte address and a bit index. It fetches the containing byte when the operation needs the bit, and writes the whole byte back when the bit must change. At the end it pulses `done` and, when the carry changes, `carry_wr` with the new value on `carry_out`.

Every operation lasts a whole number of machine cycles. A machine cycle is `MC_CLKS` clocks, 12 by default, and `MC_CLKS` must be at least 5. Logic that merges the carry with a bit takes two machine cycles, and so does storing the carry into a bit. Every other operation takes one. The unit accepts a new `start` only while idle.

The controller is a state machine with these states:
- IDLE: waits for `start`.
- READ: drives `rd_en`.
- CAPTURE: latches `rd_data`.
- WRITE: drives `wr_en`.
- WAIT: pads the operation out to its machine-cycle count.
- DONE: drives the one-cycle `done` strobe.

The transitions are:
- IDLE→READ on `start` with a bit-reading operation.
- IDLE→WAIT on `start` with a carry-only or unused operation.
- READ→CAPTURE.
- CAPTURE→WRITE for bit-writing operations.
- CAPTURE→WAIT for bit-reading-only operations.
- WRITE→WAIT.
- WAIT→DONE when the cycle timer reaches its last clock.
- DONE→IDLE.

Top module: `bit_proc`

## Requirements
- R1: After reset the unit is idle: `busy`, `done`, `rd_en`, `wr_en` and `carry_wr` are low and `carry_out` is 0.
- R2: Op codes 0 (clear carry), 1 (set carry) and 2 (invert carry) take 1 machine cycle. They make no memory read or write and return the new carry.
- R3: Bit addresses 0x00–0x7F select RAM byte 0x20 + (addr >> 3), bit addr[2:0].
- R4: Bit addresses 0x80–0xFF select special-register byte addr & 0xF8, bit addr[2:0].
- R5: Op codes 3 (clear bit), 4 (set bit) and 5 (invert bit) take 1 machine cycle. Each does one read and one write of the same byte address. The written byte differs from the byte read only in the selected bit. The carry is unchanged.
- R6: Op codes 6 (carry AND bit), 7 (carry AND inverted bit), 8 (carry OR bit) and 9 (carry OR inverted bit) take 2 machine cycles. Each does one read and no write.
- R7: Op code 10 (bit to carry) takes 1 machine cycle with one read and no write. Op code 11 (carry to bit) takes 2 machine cycles and writes the byte read back with the selected bit equal to the carry.
- R8: `done` is high for exactly one clock. That clock is the N×`MC_CLKS`-th clock after the edge that accepted `start`, where N is the operation's machine-cycle count. `busy` stays high from acceptance through that clock.
- R9: `rd_data` is taken the clock after `rd_en`. A write comes exactly two clocks after its read.
- R10: `carry_wr` pulses together with `done` for op codes 0–2 and 6–10 only. `carry_out` changes only in a clock in which `carry_wr` is high.
- R11: A `start` pulse while `busy` is high is ignored and does not disturb the operation in progress.
- R12: Op codes 12–15 are unused. Each takes 1 machine cycle with no read, no write and no carry update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| op | input | 4 | Operation code |
| bit_addr | input | 8 | Flat bit address |
| carry_in | input | 1 | Present carry value, sampled at acceptance |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-clock completion strobe |
| carry_out | output | 1 | Carry result register |
| carry_wr | output | 1 | Carry result valid and to be stored |
| rd_en | output | 1 | Byte read request |
| rd_addr | output | 8 | Byte read address |
| rd_data | input | 8 | Byte read data, valid the clock after `rd_en` |
| wr_en | output | 1 | Byte write strobe |
| wr_addr | output | 8 | Byte write address |
| wr_data | output | 8 | Byte write data |

## Verification
The assertions check the following on every clock:
- every write follows a read of the same address two clocks earlier;
- the written byte differs from the read byte in at most one bit;
- read-only operations never write;
- `done` lasts a single clock;
- `carry_out` moves only alongside `carry_wr`;
- the cycle counter never overruns its target.

Some behaviours only the bench's scenarios can show:
- the exact machine-cycle count of each op code;
- the correct bit and value under both address regions and their edges;
- the correct logic result for each carry and bit combination;
- the silence of the unused codes;
- the rejection of a `start` that arrives mid-operation.

// File: rtl/bp_pkg.sv
package bp_pkg;

    localparam int MAX_MCYC = 2;

    localparam logic [3:0] OP_CLR_C   = 4'd0;
    localparam logic [3:0] OP_SET_C   = 4'd1;
    localparam logic [3:0] OP_INV_C   = 4'd2;
    localparam logic [3:0] OP_CLR_B   = 4'd3;
    localparam logic [3:0] OP_SET_B   = 4'd4;
    localparam logic [3:0] OP_INV_B   = 4'd5;
    localparam logic [3:0] OP_AND_B   = 4'd6;
    localparam logic [3:0] OP_AND_NB  = 4'd7;
    localparam logic [3:0] OP_OR_B    = 4'd8;
    localparam logic [3:0] OP_OR_NB   = 4'd9;
    localparam logic [3:0] OP_B_TO_C  = 4'd10;
    localparam logic [3:0] OP_C_TO_B  = 4'd11;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_CAPTURE,
        ST_WRITE,
        ST_WAIT,
        ST_DONE
    } bp_state_e;

    function automatic logic op_reads_bit(input logic [3:0] code);
        return (code >= OP_CLR_B) && (code <= OP_C_TO_B);
    endfunction

    function automatic logic op_writes_bit(input logic [3:0] code);
        return (code == OP_CLR_B) || (code == OP_SET_B) ||
               (code == OP_INV_B) || (code == OP_C_TO_B);
    endfunction

    function automatic logic op_writes_carry(input logic [3:0] code);
        return (code <= OP_INV_C) ||
               ((code >= OP_AND_B) && (code <= OP_B_TO_C));
    endfunction

    function automatic int unsigned op_mcycles(input logic [3:0] code);
        if (((code >= OP_AND_B) && (code <= OP_OR_NB)) || (code == OP_C_TO_B))
            return 2;
        return 1;
    endfunction

endpackage

// File: rtl/bp_addr_map.sv
module bp_addr_map #(
    parameter logic [7:0] RAM_BASE = 8'h20
) (
    input  logic [7:0] bit_addr,
    output logic [7:0] byte_addr,
    output logic [2:0] bit_idx
);
    localparam int WIN_BYTES = 16;

    always_comb begin
        bit_idx = bit_addr[2:0];
        if (bit_addr[7]) begin
            byte_addr = {bit_addr[7:3], 3'b000};
        end else begin
            byte_addr = RAM_BASE + {4'b0000, bit_addr[6:3]};
        end
    end

    always_comb begin
        if (!bit_addr[7]) begin
            assert (byte_addr - RAM_BASE < 8'(WIN_BYTES))
                else $error("AST_RAM_WINDOW"); // R3
        end
    end
endmodule

// File: rtl/bp_cycle_timer.sv
module bp_cycle_timer #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] target,
    input  logic          run,
    output logic          last
);
    logic [CW-1:0] cnt;
    logic [CW-1:0] tgt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            tgt <= '0;
        end else if (load) begin
            cnt <= CW'(1);
            tgt <= target;
        end else if (run) begin
            cnt <= cnt + CW'(1);
        end else begin
            cnt <= '0;
        end
    end

    assign last = run && (cnt == tgt - CW'(1));

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= tgt)); // R8
endmodule

// File: rtl/bp_bit_alu.sv
module bp_bit_alu
    import bp_pkg::*;
(
    input  logic [3:0] op,
    input  logic       carry,
    input  logic [7:0] byte_in,
    input  logic [2:0] idx,
    output logic       carry_new,
    output logic [7:0] byte_out
);
    logic b;

    always_comb begin
        b = byte_in[idx];
        unique case (op)
            OP_CLR_C:  carry_new = 1'b0;
            OP_SET_C:  carry_new = 1'b1;
            OP_INV_C:  carry_new = ~carry;
            OP_AND_B:  carry_new = carry & b;
            OP_AND_NB: carry_new = carry & ~b;
            OP_OR_B:   carry_new = carry | b;
            OP_OR_NB:  carry_new = carry | ~b;
            OP_B_TO_C: carry_new = b;
            default:   carry_new = carry;
        endcase
    end

    always_comb begin
        byte_out = byte_in;
        unique case (op)
            OP_CLR_B:  byte_out[idx] = 1'b0;
            OP_SET_B:  byte_out[idx] = 1'b1;
            OP_INV_B:  byte_out[idx] = ~b;
            OP_C_TO_B: byte_out[idx] = carry;
            default:   byte_out = byte_in;
        endcase
    end
endmodule

// File: rtl/bit_proc.sv
module bit_proc
    import bp_pkg::*;
#(
    parameter int         MC_CLKS  = 12,
    parameter logic [7:0] RAM_BASE = 8'h20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [3:0] op,
    input  logic [7:0] bit_addr,
    input  logic       carry_in,
    output logic       busy,
    output logic       done,
    output logic       carry_out,
    output logic       carry_wr,
    output logic       rd_en,
    output logic [7:0] rd_addr,
    input  logic [7:0] rd_data,
    output logic       wr_en,
    output logic [7:0] wr_addr,
    output logic [7:0] wr_data
);
    localparam int CW = $clog2(MAX_MCYC * MC_CLKS + 1);

    bp_state_e  state, state_nx;
    logic [3:0] op_q;
    logic       carry_q;
    logic [7:0] baddr_q;
    logic [2:0] idx_q;
    logic [7:0] byte_q;

    logic [7:0] map_addr;
    logic [2:0] map_idx;
    logic       accept;
    logic       t_last;
    logic [CW-1:0] t_target;
    logic       alu_carry;
    logic [7:0] alu_byte;

    bp_addr_map #(.RAM_BASE(RAM_BASE)) u_map (
        .bit_addr (bit_addr),
        .byte_addr(map_addr),
        .bit_idx  (map_idx)
    );

    assign accept   = (state == ST_IDLE) && start;
    assign t_target = CW'(op_mcycles(op) * MC_CLKS);

    bp_cycle_timer #(.CW(CW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .target(t_target),
        .run   (state != ST_IDLE),
        .last  (t_last)
    );

    bp_bit_alu u_alu (
        .op       (op_q),
        .carry    (carry_q),
        .byte_in  (byte_q),
        .idx      (idx_q),
        .carry_new(alu_carry),
        .byte_out (alu_byte)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (start) state_nx = op_reads_bit(op) ? ST_READ : ST_WAIT;
            ST_READ:    state_nx = ST_CAPTURE;
            ST_CAPTURE: state_nx = op_writes_bit(op_q) ? ST_WRITE : ST_WAIT;
            ST_WRITE:   state_nx = ST_WAIT;
            ST_WAIT:    if (t_last) state_nx = ST_DONE;
            ST_DONE:    state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // operand and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q      <= '0;
            carry_q   <= 1'b0;
            baddr_q   <= '0;
            idx_q     <= '0;
            byte_q    <= '0;
            carry_out <= 1'b0;
        end else begin
            if (accept) begin
                op_q    <= op;
                carry_q <= carry_in;
                baddr_q <= map_addr;
                idx_q   <= map_idx;
            end
            if (state == ST_CAPTURE) byte_q <= rd_data;
            if ((state == ST_WAIT) && t_last && op_writes_carry(op_q))
                carry_out <= alu_carry;
        end
    end

    // outputs
    always_comb begin
        busy     = (state != ST_IDLE);
        rd_en    = (state == ST_READ);
        wr_en    = (state == ST_WRITE);
        done     = (state == ST_DONE);
        carry_wr = (state == ST_DONE) && op_writes_carry(op_q);
        rd_addr  = baddr_q;
        wr_addr  = baddr_q;
        wr_data  = alu_byte;
    end

    AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(rd_en, 2)); // R9
    AST_WR_SAME_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_addr == $past(rd_addr, 2))); // R5
    AST_WR_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ($countones(wr_data ^ $past(rd_data)) <= 1)); // R5
    AST_RDONLY_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> op_writes_bit(op_q)); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_CARRY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(carry_out) |-> carry_wr); // R10
    AST_CWR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        carry_wr |-> done); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!rd_en && !wr_en && !done)); // R11
endmodule

// File: tb/tb_bit_proc.sv
module tb_bit_proc;
    localparam int MC = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [3:0] op = '0;
    logic [7:0] bit_addr = '0;
    logic       carry_in = 1'b0;
    logic       busy, done, carry_out, carry_wr, rd_en, wr_en;
    logic [7:0] rd_addr, wr_addr, wr_data;
    logic [7:0] rd_data = '0;
    logic [7:0] mem [256];

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #10 clk = ~clk;

    bit_proc #(.MC_CLKS(MC)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .bit_addr(bit_addr),
        .carry_in(carry_in), .busy(busy), .done(done), .carry_out(carry_out),
        .carry_wr(carry_wr), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    always @(posedge clk) begin
        if (rd_en) rd_data <= mem[rd_addr];
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_baddr(input logic [7:0] a);
        return a[7] ? {a[7:3], 3'b000} : (8'h20 + {4'b0, a[6:3]});
    endfunction

    function automatic int exp_mc(input logic [3:0] o);
        return ((o >= 6 && o <= 9) || o == 11) ? 2 : 1;
    endfunction

    function automatic string req_of(input logic [3:0] o);
        if (o <= 2)  return "R2";
        if (o <= 5)  return "R5";
        if (o <= 9)  return "R6";
        if (o <= 11) return "R7";
        return "R12";
    endfunction

    task automatic run_op(input logic [3:0] o, input logic [7:0] a,
                          input logic c, input bit intrude);
        logic [7:0] ba, ob, eb;
        logic [2:0] ix;
        logic       b, ec, prev_c, cw_seen;
        bit         rd, wr, wc, busy_ok;
        int         rd_n, wr_n, rd_c, wr_c, done_c;
        logic [7:0] rd_a, wr_a, wd;
        string      rq, rg;
        ba = exp_baddr(a); ix = a[2:0]; ob = mem[ba]; b = ob[ix];
        prev_c = carry_out; eb = ob; ec = prev_c; rd = (o >= 3 && o <= 11);
        wr = (o >= 3 && o <= 5) || o == 11; wc = (o <= 2) || (o >= 6 && o <= 10);
        case (o)
            0: ec = 1'b0;       1: ec = 1'b1;       2: ec = ~c;
            3: eb[ix] = 1'b0;   4: eb[ix] = 1'b1;   5: eb[ix] = ~b;
            6: ec = c & b;      7: ec = c & ~b;     8: ec = c | b;
            9: ec = c | ~b;     10: ec = b;         11: eb[ix] = c;
            default: ;
        endcase
        rq = req_of(o); rg = a[7] ? "R4" : "R3";
        rd_n = 0; wr_n = 0; rd_c = 0; wr_c = 0; done_c = 0;
        rd_a = '0; wr_a = '0; wd = '0; cw_seen = 1'b0; busy_ok = 1'b1;
        @(negedge clk);
        start = 1'b1; op = o; bit_addr = a; carry_in = c;
        for (int k = 1; k <= 200; k++) begin
            @(negedge clk);
            if (k == 1) start = 1'b0;
            if (intrude && k == 3) begin
                start = 1'b1; op = 4'd4; bit_addr = ~a; carry_in = ~c;
            end
            if (intrude && k == 4) start = 1'b0;
            if (!busy) busy_ok = 1'b0;
            if (rd_en) begin rd_n++; rd_a = rd_addr; rd_c = k; end
            if (wr_en) begin wr_n++; wr_a = wr_addr; wd = wr_data; wr_c = k; end
            if (done) begin done_c = k; cw_seen = carry_wr; break; end
        end
        chk(done_c == exp_mc(o) * MC, "R8", "done clock", done_c, exp_mc(o) * MC);
        chk(busy_ok, "R8", "busy through op", 0, 1);
        chk(rd_n == (rd ? 1 : 0), rq, "read count", rd_n, rd ? 1 : 0);
        if (rd) chk(rd_a == ba, rg, "byte address", rd_a, ba);
        chk(wr_n == (wr ? 1 : 0), rq, "write count", wr_n, wr ? 1 : 0);
        if (wr && wr_n == 1) begin
            chk(wr_a == ba, rq, "write address", wr_a, ba);
            chk(wd == eb, rq, "write data", wd, eb);
            chk(wr_c == rd_c + 2, "R9", "write after read", wr_c, rd_c + 2);
        end
        chk(cw_seen == wc, "R10", "carry_wr", cw_seen, wc);
        chk(carry_out == ec, wc ? rq : "R10", "carry_out", carry_out, ec);
        if (intrude)
            chk(rd_n == (rd ? 1 : 0) && wr_n == (wr ? 1 : 0) && done_c == exp_mc(o) * MC,
                "R11", "mid-op start ignored", done_c, exp_mc(o) * MC);
        @(negedge clk);
        chk(!done && !busy, "R8", "done single clock", done, 0);
    endtask

    initial begin
        int unused;
        unused = $urandom(32'd2024);
        for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !rd_en && !wr_en && !carry_wr && !carry_out,
            "R1", "reset state", {busy, done, rd_en, wr_en, carry_wr, carry_out}, 0);
        // directed: every code on region edges
        for (int o = 0; o < 16; o++) begin
            run_op(4'(o), 8'h00, 1'b1, 1'b0);
            run_op(4'(o), 8'h7F, 1'b0, 1'b0);
            run_op(4'(o), 8'h80, 1'b1, 1'b0);
            run_op(4'(o), 8'hFF, 1'b0, 1'b0);
        end
        run_op(4'd8, 8'hD7, 1'b0, 1'b1);
        run_op(4'd11, 8'h3A, 1'b1, 1'b1);
        run_op(4'd1, 8'h10, 1'b0, 1'b1);
        // random mix
        for (int n = 0; n < 150; n++)
            run_op(4'($urandom % 16), 8'($urandom), 1'($urandom), ($urandom % 8) == 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected below 150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule